// File: doc/BRIEF.md
# Aliased-Line Directory Coherence Controller

This block is the home-side coherence engine of a single-node memory system with four processors. Some memory lines are aliases of each other: they hold the same data under different addresses, for example a matrix and its transposed view. The controller takes one request at a time and looks up the requested line in a byte-wide bit-vector directory. That directory follows an invalidation-based modified/shared/invalid scheme. A per-line alias flag shows whether any alias of the line may be cached. If the flag is clear, the base protocol runs on the requested line alone. If the flag is set, the controller first walks the directory entries of every aliased line. A dirty alias gets an intervention to its owner, followed by a writeback. A shared alias gets one invalidation for each sharer. Only after that does the requested line get its base action.

The requester is answered with a one-cycle grant. The controller then marks every alias as uncached and flagged, and it writes the requested line's new state with its flag cleared. Only one alias of a group is ever cached. A read of either view therefore clears the other view at read time, so a later upgrade needs no extra invalidations. An address-remapping unit outside the block supplies the alias addresses: the controller presents an index on `map_idx` and reads the address on `map_addr` in the same cycle. The directory is a synchronous RAM with one-cycle read latency.

The FSM states are IDLE, READ_DIR, CHECK_AM, SCAN_MAPPED, WAIT_REPLY, SEND_DATA and UPDATE_AM. The transitions are:
- IDLE→READ_DIR when a request is accepted.
- READ_DIR→CHECK_AM unconditionally.
- CHECK_AM→SCAN_MAPPED. If the flag is set and there are aliases, the scan starts at alias 0. Otherwise it starts directly on the requested line.
- SCAN_MAPPED→WAIT_REPLY when an intervention is accepted.
- WAIT_REPLY→SCAN_MAPPED when the intervention ack arrives.
- SCAN_MAPPED→SEND_DATA once the requested line has no messages left.
- SEND_DATA→UPDATE_AM unconditionally.
- UPDATE_AM→IDLE after the write to the requested line.

SCAN_MAPPED itself steps through three phases for each line: read, evaluate and message.

Top module: `am_dir_ctrl`

## Requirements
- R1: After reset, `busy`, `msg_valid`, `grant_valid`, `wb_valid` and `dir_en` are all low.
- R2: A request is accepted only while `busy` is low. `busy` rises in the cycle after acceptance and stays high until the final directory write. A `req_valid` pulse while busy is ignored.
- R3: The directory entry layout is: bits [3:0] sharer vector (or owner ID when dirty), bit 4 dirty, bit 5 alias flag, bits [7:6] unused. For a read with the flag clear and the line dirty at another processor, the controller sends one intervention (`msg_type`=0) to the owner for the requested address, waits for `ivn_ack`, and pulses `wb_valid` with that address. The final entry is shared by the old owner and the requester, with the flag clear.
- R4: For a write with the flag clear and the line shared, the controller sends one invalidation (`msg_type`=1) to every sharer except the requester, in ascending ID order. The final entry is dirty with owner = requester.
- R5: With the flag set, each dirty alias produces one intervention to its owner, carrying the alias address. The next message waits for `ivn_ack`, and a writeback pulse follows carrying the alias address.
- R6: With the flag set, each shared alias produces one invalidation per sharer, including the requester, in ascending ID order, with the alias address.
- R7: A clean, uncached alias produces no message.
- R8: After the grant, every alias entry is written as 0x20 (flag set, uncached). Then the requested line is written with its flag cleared.
- R9: While `msg_valid` is high and `msg_ready` is low, the message fields hold steady. Each message is delivered exactly once.
- R10: Exactly one single-cycle grant is issued per request, to the requester (`grant_excl` = write), after all messages. No message follows the grant.
- R11: With an alias count of zero, no alias directory entry is touched. Only the requested line is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_addr | input | ADDR_W | Requested line address |
| req_src | input | PID_W | Requesting processor ID |
| req_write | input | 1 | 1 = write/upgrade, 0 = read |
| map_count | input | CNT_W | Number of aliases of the requested line |
| busy | output | 1 | High for the whole request |
| map_idx | output | IDX_W | Alias index being looked up |
| map_addr | input | ADDR_W | Alias address for `map_idx` |
| dir_en | output | 1 | Directory access enable |
| dir_we | output | 1 | Directory write enable |
| dir_addr | output | ADDR_W | Directory address |
| dir_wdata | output | EW | Directory write data |
| dir_rdata | input | EW | Directory read data, one cycle after a read |
| msg_valid | output | 1 | Coherence message valid |
| msg_ready | input | 1 | Message accepted |
| msg_type | output | 1 | 0 = intervention, 1 = invalidation |
| msg_target | output | PID_W | Target processor |
| msg_addr | output | ADDR_W | Line address of the message |
| ivn_ack | input | 1 | Intervention reply returned |
| wb_valid | output | 1 | Writeback of the returned line |
| wb_addr | output | ADDR_W | Writeback line address |
| grant_valid | output | 1 | Data reply to the requester |
| grant_dest | output | PID_W | Reply destination |
| grant_excl | output | 1 | Reply grants exclusive ownership |

## Verification
The hardest case to reach is a flagged request whose alias group mixes clean, dirty and shared lines. Those lines must be handled in index order, and the intervention wait and message backpressure fall in the middle of the walk. The bench preloads its directory model with such a mix and supplies the alias table through `map_addr`. An acknowledger returns `ivn_ack` a few cycles after each intervention. In a separate scenario the bench holds `msg_ready` low during an invalidation run and checks that the message fields hold steady. It then compares the ordered message log, the writebacks, the grant and the final directory contents with values it derives from the entry layout.

// File: rtl/am_dir_pkg.sv
package am_dir_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_CHECK_AM,
        ST_SCAN_MAPPED,
        ST_WAIT_REPLY,
        ST_SEND_DATA,
        ST_UPDATE_AM
    } ctrl_state_t;

    typedef enum logic [1:0] {
        PH_RD,
        PH_EVAL,
        PH_MSG
    } scan_phase_t;

    localparam logic MSG_INTERVENE  = 1'b0;
    localparam logic MSG_INVALIDATE = 1'b1;

endpackage

// File: rtl/am_line_eval.sv
// Decides which coherence messages one line needs, from its sharer field
// and dirty bit. Aliased lines are always emptied; the requested line follows
// the base read/write protocol.
module am_line_eval #(
    parameter int NPROC = 4,
    parameter int PID_W = 2
) (
    input  logic [NPROC:0]   state_bits,
    input  logic             is_alias,
    input  logic             is_write,
    input  logic [PID_W-1:0] src,
    output logic             need_ivn,
    output logic [PID_W-1:0] owner,
    output logic [NPROC-1:0] inv_mask
);
    logic             dirty;
    logic [NPROC-1:0] shr;
    logic [NPROC-1:0] src_1h;

    assign dirty  = state_bits[NPROC];
    assign shr    = state_bits[NPROC-1:0];
    assign owner  = state_bits[PID_W-1:0];
    assign src_1h = NPROC'(1) << src;

    always_comb begin
        need_ivn = dirty && (is_alias || (owner != src));
        inv_mask = '0;
        if (!dirty) begin
            if (is_alias)
                inv_mask = shr;
            else if (is_write)
                inv_mask = shr & ~src_1h;
        end
    end
endmodule

// File: rtl/am_low_pick.sv
// Lowest-set-bit picker: gives ascending processor order for invalidations.
module am_low_pick #(
    parameter int N   = 4,
    parameter int IW  = 2
) (
    input  logic [N-1:0]  mask,
    output logic [N-1:0]  first,
    output logic [IW-1:0] first_idx
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_chain
        assign seen[g+1] = seen[g] | mask[g];
        assign first[g]  = mask[g] & ~seen[g];
    end

    always_comb begin
        first_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i])
                first_idx = IW'(i);
        end
    end
endmodule

// File: rtl/am_dir_ctrl.sv
module am_dir_ctrl
    import am_dir_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int ADDR_W = 16,
    parameter int NMAP   = 16,
    localparam int PID_W = $clog2(NPROC),
    localparam int IDX_W = $clog2(NMAP),
    localparam int CNT_W = $clog2(NMAP + 1),
    localparam int EW    = NPROC + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PID_W-1:0]  req_src,
    input  logic              req_write,
    input  logic [CNT_W-1:0]  map_count,
    output logic              busy,
    output logic [IDX_W-1:0]  map_idx,
    input  logic [ADDR_W-1:0] map_addr,
    output logic              dir_en,
    output logic              dir_we,
    output logic [ADDR_W-1:0] dir_addr,
    output logic [EW-1:0]     dir_wdata,
    input  logic [EW-1:0]     dir_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic              msg_type,
    output logic [PID_W-1:0]  msg_target,
    output logic [ADDR_W-1:0] msg_addr,
    input  logic              ivn_ack,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              grant_valid,
    output logic [PID_W-1:0]  grant_dest,
    output logic              grant_excl
);
    localparam int DIRTY_B = NPROC;
    localparam int FLAG_B  = NPROC + 1;
    localparam logic [EW-1:0] ALIAS_PARKED = EW'(1) << FLAG_B;

    ctrl_state_t       state;
    scan_phase_t       phase;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] rq_addr;
    logic [PID_W-1:0]  rq_src;
    logic              rq_write;
    logic [EW-1:0]     rq_entry;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_is_req;
    logic              ivn_pend;
    logic [PID_W-1:0]  ivn_owner;
    logic [NPROC-1:0]  inv_mask;

    // line evaluation
    logic [NPROC:0]    ev_bits;
    logic              ev_need_ivn;
    logic [PID_W-1:0]  ev_owner;
    logic [NPROC-1:0]  ev_inv;
    logic [NPROC-1:0]  pick_1h;
    logic [PID_W-1:0]  pick_id;
    logic [EW-1:0]     fin_entry;
    logic [NPROC-1:0]  src_1h;
    logic              upd_alias;

    assign ev_bits = cur_is_req ? rq_entry[NPROC:0] : dir_rdata[NPROC:0];

    am_line_eval #(.NPROC(NPROC), .PID_W(PID_W)) u_eval (
        .state_bits (ev_bits),
        .is_alias   (!cur_is_req),
        .is_write   (rq_write),
        .src        (rq_src),
        .need_ivn   (ev_need_ivn),
        .owner      (ev_owner),
        .inv_mask   (ev_inv)
    );

    am_low_pick #(.N(NPROC), .IW(PID_W)) u_pick (
        .mask      (inv_mask),
        .first     (pick_1h),
        .first_idx (pick_id)
    );

    assign src_1h    = NPROC'(1) << rq_src;
    assign upd_alias = (idx < cnt);

    // final state of the requested line, alias flag cleared
    always_comb begin
        fin_entry = '0;
        fin_entry[EW-1:NPROC+2] = rq_entry[EW-1:NPROC+2];
        if (rq_write) begin
            fin_entry[DIRTY_B]   = 1'b1;
            fin_entry[PID_W-1:0] = rq_src;
        end else if (rq_entry[DIRTY_B]) begin
            fin_entry[NPROC-1:0] = (NPROC'(1) << rq_entry[PID_W-1:0]) | src_1h;
        end else begin
            fin_entry[NPROC-1:0] = rq_entry[NPROC-1:0] | src_1h;
        end
    end

    // state register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            phase      <= PH_RD;
            idx        <= '0;
            cnt        <= '0;
            rq_addr    <= '0;
            rq_src     <= '0;
            rq_write   <= 1'b0;
            rq_entry   <= '0;
            cur_addr   <= '0;
            cur_is_req <= 1'b0;
            ivn_pend   <= 1'b0;
            ivn_owner  <= '0;
            inv_mask   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq_addr  <= req_addr;
                        rq_src   <= req_src;
                        rq_write <= req_write;
                        cnt      <= (map_count > CNT_W'(NMAP)) ? CNT_W'(NMAP) : map_count;
                        state    <= ST_READ_DIR;
                    end
                end
                ST_READ_DIR: state <= ST_CHECK_AM;
                ST_CHECK_AM: begin
                    rq_entry <= dir_rdata;
                    idx      <= '0;
                    if (dir_rdata[FLAG_B] && (cnt != '0)) begin
                        cur_is_req <= 1'b0;
                        phase      <= PH_RD;
                    end else begin
                        cur_is_req <= 1'b1;
                        cur_addr   <= rq_addr;
                        phase      <= PH_EVAL;
                    end
                    state <= ST_SCAN_MAPPED;
                end
                ST_SCAN_MAPPED: begin
                    unique case (phase)
                        PH_RD: begin
                            cur_addr <= map_addr;
                            phase    <= PH_EVAL;
                        end
                        PH_EVAL: begin
                            ivn_pend  <= ev_need_ivn;
                            ivn_owner <= ev_owner;
                            inv_mask  <= ev_inv;
                            phase     <= PH_MSG;
                        end
                        default: begin
                            if (ivn_pend) begin
                                if (msg_ready)
                                    state <= ST_WAIT_REPLY;
                            end else if (inv_mask != '0) begin
                                if (msg_ready)
                                    inv_mask <= inv_mask & ~pick_1h;
                            end else if (cur_is_req) begin
                                state <= ST_SEND_DATA;
                            end else if (CNT_W'(idx + 1'b1) == cnt) begin
                                cur_is_req <= 1'b1;
                                cur_addr   <= rq_addr;
                                phase      <= PH_EVAL;
                            end else begin
                                idx   <= CNT_W'(idx + 1'b1);
                                phase <= PH_RD;
                            end
                        end
                    endcase
                end
                ST_WAIT_REPLY: begin
                    if (ivn_ack) begin
                        ivn_pend <= 1'b0;
                        state    <= ST_SCAN_MAPPED;
                    end
                end
                ST_SEND_DATA: begin
                    idx   <= '0;
                    state <= ST_UPDATE_AM;
                end
                ST_UPDATE_AM: begin
                    if (upd_alias)
                        idx <= CNT_W'(idx + 1'b1);
                    else
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        busy        = (state != ST_IDLE);
        map_idx     = idx[IDX_W-1:0];
        dir_en      = 1'b0;
        dir_we      = 1'b0;
        dir_addr    = rq_addr;
        dir_wdata   = '0;
        msg_valid   = 1'b0;
        msg_type    = MSG_INTERVENE;
        msg_target  = ivn_owner;
        msg_addr    = cur_addr;
        wb_valid    = 1'b0;
        wb_addr     = cur_addr;
        grant_valid = 1'b0;
        grant_dest  = rq_src;
        grant_excl  = rq_write;
        unique case (state)
            ST_IDLE, ST_CHECK_AM: ;
            ST_READ_DIR: dir_en = 1'b1;
            ST_SCAN_MAPPED: begin
                if (phase == PH_RD) begin
                    dir_en   = 1'b1;
                    dir_addr = map_addr;
                end else if (phase == PH_MSG) begin
                    msg_valid = ivn_pend || (inv_mask != '0);
                    if (!ivn_pend) begin
                        msg_type   = MSG_INVALIDATE;
                        msg_target = pick_id;
                    end
                end
            end
            ST_WAIT_REPLY: wb_valid = ivn_ack;
            ST_SEND_DATA:  grant_valid = 1'b1;
            ST_UPDATE_AM: begin
                dir_en = 1'b1;
                dir_we = 1'b1;
                if (upd_alias) begin
                    dir_addr  = map_addr;
                    dir_wdata = ALIAS_PARKED;
                end else begin
                    dir_wdata = fin_entry;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/am_dir_ctrl_chk.sv
module am_dir_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int PID_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              dir_en,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic              msg_type,
    input logic [PID_W-1:0]  msg_target,
    input logic [ADDR_W-1:0] msg_addr,
    input logic              ivn_ack,
    input logic              wb_valid,
    input logic              grant_valid
);
    // R2: nothing leaves the block while idle
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!msg_valid && !grant_valid && !dir_en && !wb_valid));

    // R2: an accepted request raises busy on the next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R5: a writeback only coincides with an intervention reply
    p_wb_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (ivn_ack && busy));

    // R9: a stalled message keeps its fields
    p_msg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_type)
            && $stable(msg_target) && $stable(msg_addr)));

    // R10: the grant is one cycle wide
    p_grant_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    // R10: no message follows the grant
    p_no_msg_after_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !msg_valid);
endmodule

bind am_dir_ctrl am_dir_ctrl_chk #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .dir_en      (dir_en),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_type    (msg_type),
    .msg_target  (msg_target),
    .msg_addr    (msg_addr),
    .ivn_ack     (ivn_ack),
    .wb_valid    (wb_valid),
    .grant_valid (grant_valid)
);

// File: tb/am_dir_ctrl_bench.sv
module am_dir_ctrl_bench;
    localparam int NPROC  = 4;
    localparam int ADDR_W = 16;
    localparam int NMAP   = 16;
    localparam int PID_W  = 2;
    localparam int IDX_W  = 4;
    localparam int CNT_W  = 5;
    localparam int EW     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [PID_W-1:0]  req_src = '0;
    logic              req_write = 1'b0;
    logic [CNT_W-1:0]  map_count = '0;
    logic              busy;
    logic [IDX_W-1:0]  map_idx;
    logic [ADDR_W-1:0] map_addr;
    logic              dir_en, dir_we;
    logic [ADDR_W-1:0] dir_addr;
    logic [EW-1:0]     dir_wdata;
    logic [EW-1:0]     dir_rdata = '0;
    logic              msg_valid;
    logic              msg_ready = 1'b1;
    logic              msg_type;
    logic [PID_W-1:0]  msg_target;
    logic [ADDR_W-1:0] msg_addr;
    logic              ivn_ack = 1'b0;
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic              grant_valid;
    logic [PID_W-1:0]  grant_dest;
    logic              grant_excl;

    always #2 clk = ~clk;

    am_dir_ctrl #(.NPROC(NPROC), .ADDR_W(ADDR_W), .NMAP(NMAP)) u_am_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_src(req_src), .req_write(req_write), .map_count(map_count),
        .busy(busy), .map_idx(map_idx), .map_addr(map_addr),
        .dir_en(dir_en), .dir_we(dir_we), .dir_addr(dir_addr),
        .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_type(msg_type),
        .msg_target(msg_target), .msg_addr(msg_addr), .ivn_ack(ivn_ack),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .grant_valid(grant_valid),
        .grant_dest(grant_dest), .grant_excl(grant_excl)
    );

    // environment: directory RAM and alias table
    logic [EW-1:0]     dmem [0:255];
    logic [ADDR_W-1:0] mtab [0:NMAP-1];
    assign map_addr = mtab[map_idx];

    always @(posedge clk) begin
        if (dir_en) begin
            if (dir_we) dmem[dir_addr[7:0]] <= dir_wdata;
            else        dir_rdata <= dmem[dir_addr[7:0]];
        end
    end

    // logs
    int n_msg, n_wb, n_grant, n_dw;
    logic              lg_type [0:31];
    logic [PID_W-1:0]  lg_tgt  [0:31];
    logic [ADDR_W-1:0] lg_addr [0:31];
    logic [ADDR_W-1:0] lg_wb;
    logic [PID_W-1:0]  lg_gd;
    logic              lg_ge;

    always @(negedge clk) begin
        if (msg_valid && msg_ready && n_msg < 32) begin
            lg_type[n_msg] = msg_type;
            lg_tgt[n_msg]  = msg_target;
            lg_addr[n_msg] = msg_addr;
            n_msg++;
        end
        if (wb_valid) begin lg_wb = wb_addr; n_wb++; end
        if (grant_valid) begin lg_gd = grant_dest; lg_ge = grant_excl; n_grant++; end
        if (dir_we) n_dw++;
    end

    // intervention acknowledger
    initial begin
        forever begin
            @(negedge clk);
            if (msg_valid && msg_ready && msg_type == 1'b0) begin
                repeat (3) @(negedge clk);
                ivn_ack = 1'b1;
                @(negedge clk);
                ivn_ack = 1'b0;
            end
        end
    end

    int total = 0, bad = 0;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_msg(string tag, int i, logic t, int tgt, int a);
        check({tag, " type"}, int'(lg_type[i]), int'(t));
        check({tag, " target"}, int'(lg_tgt[i]), tgt);
        check({tag, " addr"}, int'(lg_addr[i]), a);
    endtask

    task automatic clear_logs();
        n_msg = 0; n_wb = 0; n_grant = 0; n_dw = 0;
    endtask

    task automatic run_req(int a, int s, bit w, int c);
        @(negedge clk);
        req_addr  = ADDR_W'(a);
        req_src   = PID_W'(s);
        req_write = w;
        map_count = CNT_W'(c);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy), 0);
        check("R1 msg_valid", int'(msg_valid), 0);
        check("R1 grant", int'(grant_valid), 0);
        check("R1 wb/dir", int'(wb_valid | dir_en), 0);
    endtask

    task automatic t_clear_read_dirty();
        clear_logs();
        dmem[8'h10] = 8'h12;
        mtab[0] = 16'h40; mtab[1] = 16'h41; mtab[2] = 16'h42;
        run_req(16'h10, 0, 1'b0, 3);
        check("R3 msg count", n_msg, 1);
        check_msg("R3 ivn", 0, 1'b0, 2, 16'h10);
        check("R3 wb count", n_wb, 1);
        check("R3 wb addr", int'(lg_wb), 16'h10);
        check("R10 grant count", n_grant, 1);
        check("R10 grant dest/excl", int'({lg_gd, lg_ge}), 0);
        check("R3 final entry", int'(dmem[8'h10]), 8'h05);
        for (int i = 0; i < 3; i++) check("R8 alias parked", int'(dmem[8'h40 + i]), 8'h20);
        check("R8 dir writes", n_dw, 4);
    endtask

    task automatic t_clear_write_shared();
        clear_logs();
        dmem[8'h11] = 8'h0B;
        mtab[0] = 16'h50;
        run_req(16'h11, 1, 1'b1, 1);
        check("R4 msg count", n_msg, 2);
        check_msg("R4 inv0", 0, 1'b1, 0, 16'h11);
        check_msg("R4 inv3", 1, 1'b1, 3, 16'h11);
        check("R10 grant excl", int'({lg_gd, lg_ge}), 3);
        check("R4 final entry", int'(dmem[8'h11]), 8'h11);
        check("R8 alias parked", int'(dmem[8'h50]), 8'h20);
    endtask

    task automatic t_flag_set_mix();
        clear_logs();
        dmem[8'h20] = 8'h20;
        dmem[8'h60] = 8'h20; dmem[8'h61] = 8'h31; dmem[8'h62] = 8'h25;
        mtab[0] = 16'h60; mtab[1] = 16'h61; mtab[2] = 16'h62;
        run_req(16'h20, 0, 1'b0, 3);
        check("R7 R5 R6 msg count", n_msg, 3);
        check_msg("R5 ivn alias", 0, 1'b0, 1, 16'h61);
        check_msg("R6 inv p0", 1, 1'b1, 0, 16'h62);
        check_msg("R6 inv p2", 2, 1'b1, 2, 16'h62);
        check("R5 wb count", n_wb, 1);
        check("R5 wb addr", int'(lg_wb), 16'h61);
        check("R10 grant count", n_grant, 1);
        for (int i = 0; i < 3; i++) check("R8 alias parked", int'(dmem[8'h60 + i]), 8'h20);
        check("R8 req flag clear", int'(dmem[8'h20]), 8'h01);
    endtask

    task automatic t_backpressure();
        logic [PID_W-1:0]  t0;
        logic [ADDR_W-1:0] a0;
        clear_logs();
        dmem[8'h30] = 8'h20;
        dmem[8'h70] = 8'h2E;
        mtab[0] = 16'h70;
        msg_ready = 1'b0;
        fork
            run_req(16'h30, 3, 1'b1, 1);
            begin
                for (int k = 0; k < 50 && !msg_valid; k++) @(negedge clk);
                t0 = msg_target; a0 = msg_addr;
                repeat (4) @(negedge clk);
                check("R9 held valid", int'(msg_valid), 1);
                check("R9 held target", int'(msg_target), int'(t0));
                check("R9 held addr", int'(msg_addr), int'(a0));
                msg_ready = 1'b1;
            end
        join
        check("R9 delivered once", n_msg, 3);
        check_msg("R9 inv1", 0, 1'b1, 1, 16'h70);
        check_msg("R9 inv3", 2, 1'b1, 3, 16'h70);
        check("R4 final entry", int'(dmem[8'h30]), 8'h13);
    endtask

    task automatic t_no_alias();
        clear_logs();
        dmem[8'h38] = 8'h00;
        run_req(16'h38, 2, 1'b1, 0);
        check("R11 msg count", n_msg, 0);
        check("R11 dir writes", n_dw, 1);
        check("R11 final entry", int'(dmem[8'h38]), 8'h12);
        check("R10 grant count", n_grant, 1);
    endtask

    task automatic t_busy_ignore();
        clear_logs();
        dmem[8'h3A] = 8'h00; dmem[8'h3C] = 8'h00;
        mtab[0] = 16'h7A; mtab[1] = 16'h7B;
        fork
            run_req(16'h3A, 1, 1'b0, 2);
            begin
                repeat (3) @(negedge clk);
                check("R2 busy high", int'(busy), 1);
                req_addr = 16'h3C; req_src = 2'd3; req_write = 1'b1;
                req_valid = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        check("R2 one grant", n_grant, 1);
        check("R2 ignored line", int'(dmem[8'h3C]), 8'h00);
        check("R2 served line", int'(dmem[8'h3A]), 8'h02);
        check("R2 idle after", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = '0;
        for (int i = 0; i < NMAP; i++) mtab[i] = '0;
        clear_logs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clear_read_dirty();
        t_clear_write_shared();
        t_flag_set_mix();
        t_backpressure();
        t_no_alias();
        t_busy_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule